// File: doc/BRIEF.md
# Wired Interrupt Source Bank

This block keeps the per-source state of a bank of wired interrupt lines that are numbered from 1 up to `NSRC-1`. Slot 0 does not exist. Each source has a configuration word, a pending bit, an enable bit and a copy of its line level from the previous cycle. The configuration holds a trigger mode or a delegate flag with a child index. The trigger mode sets how the raw line sets pending. It also sets which software requests to set or clear pending are honoured.

Software reaches the state over a 32-bit register bus. Every access completes in one cycle, and read data is registered. The bus offers per-source configuration words and word-wide set and clear arrays for pending and enable. It also offers set-by-number and clear-by-number registers, including a byte-swapped variant for setting pending. Each source drives a flag that is high when the source is both enabled and pending. A downstream delivery stage uses these flags. A build parameter picks direct delivery or message delivery, and this changes which software pending writes take effect on level-triggered sources.

Top module: `irq_src_bank`

## Requirements
- R1: After reset every configuration word, pending bit, enable bit, sampled input and `src_ready` bit is zero.
- R2: A configuration word for source s sits at byte offset 4*s. If bit 10 (delegate) is written as 1, the stored word keeps bit 10 and bits 9:0. Otherwise it keeps only bits 2:0. If no child domains exist (`NUM_CHILD`=0), a write with bit 10 set stores zero. Writes to source 0, or to a source at or above `NSRC`, are dropped, and those words read zero.
- R3: Writing a configuration word that is delegated or all zero clears that source's pending and enable bits.
- R4: Mode 4 (rising edge) sets pending when the line is high and its sampled value was low. Mode 5 (falling edge) sets pending when the line is low and its sampled value was high.
- R5: Mode 6 (level high) sets pending whenever the line is high. Mode 7 (level low) sets pending whenever the line is low. The sampled input follows the line every cycle, whatever the mode.
- R6: Software set and clear of pending have no effect on inactive sources (mode 0) or on delegated sources. With direct delivery, both are also ignored for modes 6 and 7. With message delivery, a set is honoured on modes 6 and 7 but a clear is not.
- R7: Software set and clear of enable have no effect on inactive or delegated sources.
- R8: There are four word-wide arrays, and bit i of word w maps to source 32*w+i:
  - Set-pending at 0x400+4w. Writing 1 bits sets pending. A read returns the pending bits.
  - Clear-pending at 0x480+4w. Writing 1 bits clears pending. A read returns the raw sampled line levels.
  - Set-enable at 0x500+4w. Writing 1 bits sets enable. A read returns the enable bits.
  - Clear-enable at 0x580+4w. Writing 1 bits clears enable. A read returns zero.
  Bits for source 0, or for sources at or above `NSRC`, are ignored.
- R9: The by-number registers act on the source number written:
  - 0x600 sets pending.
  - 0x604 clears pending.
  - 0x608 sets enable.
  - 0x60C clears enable.
  - 0x610 byte-swaps the written value and then sets pending.
  All of them read zero. Numbers 0 and at or above `NSRC` are ignored.
- R10: An access whose address is not a multiple of 4 changes nothing and reads zero.
- R11: `src_ready[s]` is high exactly when source s is both enabled and pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| src_in | input | NSRC | Raw source lines, synchronous to clk, bit 0 unused |
| src_ready | output | NSRC | Per-source enabled-and-pending flags |

## Verification
The trigger logic is driven with several line patterns:
- Holding a line at one level separates edge modes from level modes.
- A high-to-low step only on a falling-edge source, and a low-to-high step only on a rising-edge source, separate the two edge polarities.
- A line that stays high after its pending bit is cleared shows that an edge source does not set pending again without a new transition.

Software pending writes are aimed at level sources on a direct-delivery instance and on a message-delivery instance side by side, and the results must differ exactly as R6 states. Out-of-range numbers, source 0, byte-swapped numbers and misaligned addresses show that only the intended slot is touched.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

   localparam int CFG_W     = 11;
   localparam int DELEG_BIT = 10;

   typedef enum logic [2:0] {
      TM_OFF    = 3'd0,
      TM_DETACH = 3'd1,
      TM_RISE   = 3'd4,
      TM_FALL   = 3'd5,
      TM_HIGH   = 3'd6,
      TM_LOW    = 3'd7
   } trig_mode_e;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_CFG,
      RK_PEND,
      RK_IN,
      RK_EN
   } rd_kind_e;

   // arr_we / num_we bit order: 0 pend set, 1 pend clear, 2 en set, 3 en clear
   typedef struct packed {
      logic        cfg_we;
      logic [3:0]  arr_we;
      logic [3:0]  num_we;
      logic [7:0]  idx;
      logic [4:0]  word;
      logic [31:0] num_val;
      rd_kind_e    rd_kind;
   } acc_t;

   function automatic logic [CFG_W-1:0] shape_cfg(logic [31:0] v, bit has_child);
      if (v[DELEG_BIT] && has_child) return {1'b1, v[9:0]};
      else if (v[DELEG_BIT])         return '0;
      else                           return {8'b0, v[2:0]};
   endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_src_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output acc_t              acc
);

   localparam logic [ADDR_W-1:0] A_ARR  = ADDR_W'(32'h400);
   localparam logic [ADDR_W-1:0] A_NUM  = ADDR_W'(32'h600);
   localparam logic [ADDR_W-1:0] A_PCLR = ADDR_W'(32'h604);
   localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(32'h608);
   localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(32'h60C);
   localparam logic [ADDR_W-1:0] A_BSET = ADDR_W'(32'h610);

   logic wr;
   logic swap;

   always_comb begin
      wr          = bus_valid && bus_write;
      swap        = 1'b0;
      acc         = '0;
      acc.rd_kind = RK_NONE;
      acc.idx     = bus_addr[9:2];
      acc.word    = bus_addr[6:2];
      if (bus_addr[1:0] == 2'b00) begin
         if (bus_addr < A_ARR) begin
            acc.rd_kind = RK_CFG;
            acc.cfg_we  = wr;
         end else if (bus_addr < A_NUM) begin
            case (bus_addr[8:7])
               2'd0:    begin acc.rd_kind = RK_PEND; acc.arr_we[0] = wr; end
               2'd1:    begin acc.rd_kind = RK_IN;   acc.arr_we[1] = wr; end
               2'd2:    begin acc.rd_kind = RK_EN;   acc.arr_we[2] = wr; end
               default: acc.arr_we[3] = wr;
            endcase
         end else begin
            if (bus_addr == A_NUM)  acc.num_we[0] = wr;
            if (bus_addr == A_PCLR) acc.num_we[1] = wr;
            if (bus_addr == A_ESET) acc.num_we[2] = wr;
            if (bus_addr == A_ECLR) acc.num_we[3] = wr;
            if (bus_addr == A_BSET) begin
               acc.num_we[0] = wr;
               swap          = 1'b1;
            end
         end
      end
      acc.num_val = swap ? {bus_wdata[7:0], bus_wdata[15:8], bus_wdata[23:16], bus_wdata[31:24]}
                         : bus_wdata;
   end

   // At most one kind of write strobe per access (R9, R10)
   always_comb begin
      p_one_op_r9: assert ($onehot0({acc.cfg_we, acc.arr_we, acc.num_we}))
         else $error("more than one write strobe decoded");
   end

endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
   import irq_src_pkg::*;
#(
   parameter bit MSI_MODE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_in,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wval,
   input  logic             sw_pset,
   input  logic             sw_pclr,
   input  logic             sw_eset,
   input  logic             sw_eclr,
   output logic [CFG_W-1:0] cfg_q,
   output logic             pend_q,
   output logic             en_q,
   output logic             in_q
);

   logic       deleg;
   logic [2:0] mode;
   logic       live;
   logic       is_lvl;
   logic       hw_set;
   logic       set_ok;
   logic       clr_ok;
   logic       wipe;
   logic       pend_n;
   logic       en_n;

   assign deleg  = cfg_q[DELEG_BIT];
   assign mode   = cfg_q[2:0];
   assign live   = !deleg && (mode != TM_OFF);
   assign is_lvl = (mode == TM_HIGH) || (mode == TM_LOW);
   assign clr_ok = live && !is_lvl;
   assign wipe   = cfg_we && (cfg_wval[DELEG_BIT] || (cfg_wval == '0));

   generate
      if (MSI_MODE) begin : g_msi
         assign set_ok = live;
      end else begin : g_direct
         assign set_ok = live && !is_lvl;
      end
   endgenerate

   always_comb begin
      hw_set = 1'b0;
      if (!deleg && !pend_q) begin
         case (mode)
            TM_RISE: hw_set = line_in && !in_q;
            TM_FALL: hw_set = !line_in && in_q;
            TM_HIGH: hw_set = line_in;
            TM_LOW:  hw_set = !line_in;
            default: hw_set = 1'b0;
         endcase
      end
   end

   always_comb begin
      pend_n = pend_q;
      if (hw_set)             pend_n = 1'b1;
      if (sw_pset && set_ok)  pend_n = 1'b1;
      if (sw_pclr && clr_ok)  pend_n = 1'b0;
      en_n = en_q;
      if (sw_eset && live)    en_n = 1'b1;
      if (sw_eclr && live)    en_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         pend_q <= 1'b0;
         en_q   <= 1'b0;
         in_q   <= 1'b0;
      end else begin
         in_q   <= line_in;
         if (cfg_we) cfg_q <= cfg_wval;
         pend_q <= wipe ? 1'b0 : pend_n;
         en_q   <= wipe ? 1'b0 : en_n;
      end
   end

   p_wipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && (cfg_wval[DELEG_BIT] || (cfg_wval == '0)) |=> !pend_q && !en_q);

   p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !deleg && (mode == TM_RISE) && line_in && !in_q && !cfg_we && !sw_pclr |=> pend_q);

   p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !deleg && (mode == TM_HIGH) && line_in && !cfg_we |=> pend_q);

   p_dead_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !live && !pend_q && !cfg_we |=> !pend_q);

   p_dead_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !live && !en_q && !cfg_we |=> !en_q);

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_src_pkg::*;
#(
   parameter int NSRC      = 40,
   parameter int NUM_CHILD = 1,
   parameter bit MSI_MODE  = 1'b0,
   parameter int ADDR_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NSRC-1:0]   src_in,
   output logic [NSRC-1:0]   src_ready
);

   localparam int  WORDS     = (NSRC + 31) / 32;
   localparam bit  HAS_CHILD = (NUM_CHILD > 0);

   generate
      if (NSRC < 2 || NSRC > 256) begin : g_bad_nsrc
         $error("NSRC must lie in 2..256");
      end
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must be at least 11");
      end
   endgenerate

   acc_t             acc;
   logic [CFG_W-1:0] cfg_new;
   logic [CFG_W-1:0] cfg_v [NSRC];
   logic [NSRC-1:0]  pend_v, en_v, in_v;
   logic [WORDS*32-1:0] pend_all, en_all, in_all;
   logic [31:0]      rd_mux;

   irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .acc       (acc)
   );

   assign cfg_new = shape_cfg(bus_wdata, HAS_CHILD);

   assign cfg_v[0]  = '0;
   assign pend_v[0] = 1'b0;
   assign en_v[0]   = 1'b0;
   assign in_v[0]   = 1'b0;

   generate
      for (genvar s = 1; s < NSRC; s++) begin : g_slot
         localparam int W = s / 32;
         localparam int B = s % 32;
         logic pset, pclr, eset, eclr, cwe;

         assign cwe  = acc.cfg_we && (acc.idx == 8'(s));
         assign pset = (acc.arr_we[0] && acc.word == 5'(W) && bus_wdata[B]) ||
                       (acc.num_we[0] && acc.num_val == 32'(s));
         assign pclr = (acc.arr_we[1] && acc.word == 5'(W) && bus_wdata[B]) ||
                       (acc.num_we[1] && acc.num_val == 32'(s));
         assign eset = (acc.arr_we[2] && acc.word == 5'(W) && bus_wdata[B]) ||
                       (acc.num_we[2] && acc.num_val == 32'(s));
         assign eclr = (acc.arr_we[3] && acc.word == 5'(W) && bus_wdata[B]) ||
                       (acc.num_we[3] && acc.num_val == 32'(s));

         irq_src_slot #(.MSI_MODE(MSI_MODE)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (src_in[s]),
            .cfg_we   (cwe),
            .cfg_wval (cfg_new),
            .sw_pset  (pset),
            .sw_pclr  (pclr),
            .sw_eset  (eset),
            .sw_eclr  (eclr),
            .cfg_q    (cfg_v[s]),
            .pend_q   (pend_v[s]),
            .en_q     (en_v[s]),
            .in_q     (in_v[s])
         );
      end
   endgenerate

   assign src_ready = pend_v & en_v;

   always_comb begin
      pend_all = '0;
      en_all   = '0;
      in_all   = '0;
      pend_all[NSRC-1:0] = pend_v;
      en_all[NSRC-1:0]   = en_v;
      in_all[NSRC-1:0]   = in_v;
   end

   always_comb begin
      rd_mux = '0;
      case (acc.rd_kind)
         RK_CFG:
            for (int s = 0; s < NSRC; s++)
               if (acc.idx == 8'(s)) rd_mux = 32'(cfg_v[s]);
         RK_PEND:
            for (int w = 0; w < WORDS; w++)
               if (acc.word == 5'(w)) rd_mux = pend_all[w*32 +: 32];
         RK_IN:
            for (int w = 0; w < WORDS; w++)
               if (acc.word == 5'(w)) rd_mux = in_all[w*32 +: 32];
         RK_EN:
            for (int w = 0; w < WORDS; w++)
               if (acc.word == 5'(w)) rd_mux = en_all[w*32 +: 32];
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bus_rdata <= '0;
      else if (bus_valid && !bus_write) bus_rdata <= rd_mux;
   end

   p_misalign_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_write && (bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

   p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_write && (bus_addr[1:0] != 2'b00) |=> $stable(src_ready));

endmodule

// File: tb/irq_src_bank_tb.sv
`timescale 1ns/1ps
module irq_src_bank_tb;

   localparam int N = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [N-1:0] src_in = '0;
   logic [31:0] rdata_a, rdata_b;
   logic [N-1:0] ready_a, ready_b;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   irq_src_bank #(.NSRC(N), .NUM_CHILD(1), .MSI_MODE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
      .src_in(src_in), .src_ready(ready_a));

   irq_src_bank #(.NSRC(N), .NUM_CHILD(0), .MSI_MODE(1'b1)) u_dut_msi (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
      .src_in(src_in), .src_ready(ready_b));

   task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", what, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] ra, output logic [31:0] rb);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      ra = rdata_a; rb = rdata_b;
   endtask

   task automatic set_line(input int s, input logic v);
      @(negedge clk);
      src_in[s] = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] a, b;
      chk("R1 ready a after reset", 64'(ready_a), 0);
      chk("R1 ready b after reset", 64'(ready_b), 0);
      rd(12'h400, a, b);
      chk("R1 pending word0 a", 64'(a), 0);
      chk("R1 pending word0 b", 64'(b), 0);
      rd(12'h004, a, b);
      chk("R1 cfg1 a", 64'(a), 0);
   endtask

   task automatic t_config;
      logic [31:0] a, b;
      wr(12'h004, 32'd4);
      wr(12'h008, 32'd5);
      wr(12'h00C, 32'hFFFF_FBF6);
      rd(12'h00C, a, b);
      chk("R2 mode word keeps low 3 bits", 64'(a), 64'h6);
      wr(12'h010, 32'd7);
      wr(12'h014, 32'h0000_07FF);
      rd(12'h014, a, b);
      chk("R2 delegated word with child", 64'(a), 64'h7FF);
      chk("R2 delegate forced zero without child", 64'(b), 0);
      wr(12'h018, 32'd6);
      wr(12'h000, 32'd4);
      rd(12'h000, a, b);
      chk("R2 source 0 config", 64'(a), 0);
      wr(12'h0A0, 32'd4);
      rd(12'h0A0, a, b);
      chk("R2 source N config", 64'(a), 0);
   endtask

   task automatic t_edge;
      logic [31:0] a, b;
      rd(12'h400, a, b);
      chk("R5 level low sets pending", 64'(a), 64'h10);
      set_line(2, 1'b1);
      rd(12'h400, a, b);
      chk("R4 falling mode ignores rise", 64'(a), 64'h10);
      @(negedge clk);
      src_in[1] = 1'b1; src_in[2] = 1'b0;
      repeat (2) @(negedge clk);
      rd(12'h400, a, b);
      chk("R4 rise and fall set pending a", 64'(a), 64'h16);
      chk("R4 rise and fall set pending b", 64'(b), 64'h16);
      wr(12'h604, 32'd1);
      wr(12'h604, 32'd2);
      rd(12'h400, a, b);
      chk("R4 no retrigger on steady high", 64'(a), 64'h10);
   endtask

   task automatic t_level;
      logic [31:0] a, b;
      set_line(3, 1'b1);
      rd(12'h400, a, b);
      chk("R5 level high sets pending", 64'(a), 64'h18);
      wr(12'h604, 32'd3);
      rd(12'h400, a, b);
      chk("R6 clear on level ignored direct", 64'(a), 64'h18);
      chk("R6 clear on level ignored msi", 64'(b), 64'h18);
      wr(12'h600, 32'd6);
      rd(12'h400, a, b);
      chk("R6 set on level ignored direct", 64'(a), 64'h18);
      chk("R6 set on level honoured msi", 64'(b), 64'h58);
      wr(12'h400, 32'h80);
      rd(12'h400, a, b);
      chk("R6 set on inactive ignored", 64'(a), 64'h18);
      rd(12'h480, a, b);
      chk("R8 clear array reads raw lines", 64'(a), 64'h0A);
   endtask

   task automatic t_enable;
      logic [31:0] a, b;
      wr(12'h500, 32'h7F);
      rd(12'h500, a, b);
      chk("R7 enable skips inactive/delegated a", 64'(a), 64'h5E);
      chk("R7 enable skips inactive b", 64'(b), 64'h5E);
      chk("R11 ready a", 64'(ready_a), 64'h18);
      chk("R11 ready b", 64'(ready_b), 64'h58);
      wr(12'h60C, 32'd1);
      wr(12'h608, 32'd7);
      rd(12'h500, a, b);
      chk("R9 enable by number", 64'(a), 64'h5C);
      rd(12'h580, a, b);
      chk("R8 clear-enable array reads zero", 64'(a), 0);
   endtask

   task automatic t_wipe;
      logic [31:0] a, b;
      wr(12'h00C, 32'd0);
      rd(12'h400, a, b);
      chk("R3 zero config clears pending a", 64'(a), 64'h10);
      chk("R3 zero config clears pending b", 64'(b), 64'h50);
      rd(12'h500, a, b);
      chk("R3 zero config clears enable", 64'(a), 64'h54);
   endtask

   task automatic t_number;
      logic [31:0] a, b;
      wr(12'h084, 32'd4);
      wr(12'h610, 32'h2100_0000);
      rd(12'h404, a, b);
      chk("R9 byte-swapped set hits source 33", 64'(a), 64'h2);
      rd(12'h610, a, b);
      chk("R9 number register reads zero", 64'(a), 0);
      wr(12'h600, 32'd0);
      wr(12'h600, 32'd40);
      wr(12'h600, 32'd5);
      wr(12'h404, 32'h100);
      wr(12'h400, 32'h1);
      rd(12'h400, a, b);
      chk("R9 out-of-range numbers ignored a", 64'(a), 64'h10);
      chk("R9 out-of-range numbers ignored b", 64'(b), 64'h50);
      rd(12'h404, a, b);
      chk("R8 bit for source N ignored", 64'(a), 64'h2);
      wr(12'h484, 32'h2);
      rd(12'h404, a, b);
      chk("R8 clear array word 1", 64'(a), 0);
   endtask

   task automatic t_misalign;
      logic [31:0] a, b;
      wr(12'h402, 32'hFFFF_FFFF);
      rd(12'h400, a, b);
      chk("R10 misaligned write ignored", 64'(a), 64'h10);
      rd(12'h401, a, b);
      chk("R10 misaligned read zero", 64'(a), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_config;
      t_edge;
      t_level;
      t_enable;
      t_wipe;
      t_number;
      t_misalign;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule